// File: doc/BRIEF.md
# Single-Port RAM with Read-Enable Output Control

This block is a synchronous single-port memory. One address bus serves both reads and writes. It is organised as byte lanes of a configurable width, so a write can update any subset of the lanes through a per-lane mask. A single rising-edge clock drives every register, and a clock enable gates all of them.

Every command is taken on a rising edge where the clock enable is high. The block first resolves an effective address: the address input, or, while the stall input is high, the address held from the previous accepted edge. A write updates the enabled lanes at that address on the same edge. A read loads the output register on that edge, so the result appears on the output one cycle after the command. The output register only changes when the read enable is high. This lets a write either show its effect on the output or leave the last read value in place. When a read and a write happen together, a build-time mode chooses what the output shows: the word as it stands after the write, or the word as it stood before it.

Top module: `spram_rdctl`

## Requirements
- R1: A word written with every lane enabled is returned on `rdata` in the cycle after a later accepted read of the same address.
- R2: Bit k of `byte_en` enables lane k, which covers data bits [k*BYTE_W+BYTE_W-1 : k*BYTE_W], with bit 0 on the least significant lane. With 18-bit data and 9-bit lanes, `byte_en`=2'b01 writes only bits 8..0 and 2'b11 writes all 18 bits. Lanes that are not enabled keep their stored value.
- R3: With RDW_MODE = RDW_SHOW_NEW, an accepted edge with both `rd_en` and `wr_en` high loads `rdata` with the word at that address after the masked write is applied.
- R4: With RDW_MODE = RDW_SHOW_OLD, an accepted edge with both `rd_en` and `wr_en` high loads `rdata` with the word at that address before the write.
- R5: On an accepted edge with `rd_en` low, `rdata` keeps its value, whether or not a write takes place.
- R6: While `addr_stall` is 1 on an accepted edge, the read or write uses the address held from the last accepted edge, `addr` is ignored, and the held address does not change.
- R7: While `addr_stall` is 0 on an accepted edge, the command uses `addr`, and `addr` becomes the held address.
- R8: On an edge with `clk_en` low, nothing is written, `rdata` does not change and the held address does not change.
- R9: An active-low reset clears the held address and `rdata` to zero. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Clock enable for all registers and for writes |
| addr | input | AW = clog2(DEPTH) | Shared read/write address |
| addr_stall | input | 1 | 1 = keep the held address and ignore `addr` |
| wr_en | input | 1 | Write command |
| rd_en | input | 1 | Read command; allows `rdata` to load |
| byte_en | input | DATA_W/BYTE_W | Per-lane write mask, bit 0 = lowest lane |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |

## Verification
Some behaviours are checked by assertions on every cycle:
- The output holds whenever no read is accepted.
- Every register freezes while the clock enable is low.
- A stalled edge keeps the held address.
- An enabled lane stores its data.
- In new-data mode, a full-width simultaneous read and write shows the written word.

Other behaviours can only be shown by the bench scenarios, because they involve a sequence of commands:
- Partial-mask merging, checked by reading back later.
- Old-data returns when a read and a write happen together.
- Reads after a stalled write landing at the held address rather than the presented one.
- The held address after reset being zero.

The bench drives one stimulus stream into two instances, one built in each read-during-write mode, and compares both against a model.

// File: rtl/spram_pkg.sv
package spram_pkg;
    typedef enum logic {
        RDW_SHOW_NEW = 1'b0,
        RDW_SHOW_OLD = 1'b1
    } rdw_mode_e;
endpackage

// File: rtl/spram_addr_hold.sv
module spram_addr_hold #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          stall,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] eff_addr
);
    typedef struct packed {
        logic [AW-1:0] held;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        eff_addr = stall ? st_q.held : addr_in;
        if (clk_en) begin
            st_d.held = eff_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_STALL_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && clk_en) |=> (st_q.held == $past(st_q.held))); // R6
    AST_CE_OFF_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en) |=> $stable(st_q.held)); // R8
endmodule

// File: rtl/spram_lane_bank.sv
module spram_lane_bank #(
    parameter int DEPTH  = 64,
    parameter int BYTE_W = 9,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              wr_stb,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] wr_lane,
    output logic [BYTE_W-1:0] rd_lane
);
    logic [BYTE_W-1:0] cells_q [DEPTH];
    logic [BYTE_W-1:0] cell_d;
    logic              we_d;

    always_comb begin
        rd_lane = cells_q[addr];
        we_d    = wr_stb;
        cell_d  = wr_stb ? wr_lane : cells_q[addr];
    end

    always_ff @(posedge clk) begin
        if (we_d) begin
            cells_q[addr] <= cell_d;
        end
    end

    AST_LANE_STORES: assert property (@(posedge clk)
        wr_stb |=> (cells_q[$past(addr)] == $past(wr_lane))); // R2
endmodule

// File: rtl/spram_out_stage.sv
module spram_out_stage #(
    parameter int                   DATA_W   = 18,
    parameter spram_pkg::rdw_mode_e RDW_MODE = spram_pkg::RDW_SHOW_NEW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] new_word,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] dout;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clk_en && rd_en) begin
            if (wr_en && (RDW_MODE == spram_pkg::RDW_SHOW_NEW)) begin
                st_d.dout = new_word;
            end else begin
                st_d.dout = old_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.dout;

    AST_NO_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |=> $stable(rdata)); // R5
endmodule

// File: rtl/spram_rdctl.sv
module spram_rdctl #(
    parameter int                   DEPTH    = 64,
    parameter int                   DATA_W   = 18,
    parameter int                   BYTE_W   = 9,
    parameter spram_pkg::rdw_mode_e RDW_MODE = spram_pkg::RDW_SHOW_NEW,
    localparam int                  AW       = $clog2(DEPTH),
    localparam int                  LANES    = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic [AW-1:0]     addr,
    input  logic              addr_stall,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [LANES-1:0]  byte_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [AW-1:0]     eff_addr;
    logic [DATA_W-1:0] old_word;
    logic [DATA_W-1:0] new_word;

    spram_addr_hold #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .stall    (addr_stall),
        .addr_in  (addr),
        .eff_addr (eff_addr)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_we;
        assign lane_we = clk_en && wr_en && byte_en[g];
        assign new_word[g*BYTE_W +: BYTE_W] = byte_en[g] ? wdata[g*BYTE_W +: BYTE_W]
                                                         : old_word[g*BYTE_W +: BYTE_W];
        spram_lane_bank #(.DEPTH(DEPTH), .BYTE_W(BYTE_W), .AW(AW)) u_bank (
            .clk     (clk),
            .wr_stb  (lane_we),
            .addr    (eff_addr),
            .wr_lane (wdata[g*BYTE_W +: BYTE_W]),
            .rd_lane (old_word[g*BYTE_W +: BYTE_W])
        );
    end

    spram_out_stage #(.DATA_W(DATA_W), .RDW_MODE(RDW_MODE)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .old_word (old_word),
        .new_word (new_word),
        .rdata    (rdata)
    );

    AST_CE_OFF_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en) |=> $stable(rdata)); // R8

    if (RDW_MODE == spram_pkg::RDW_SHOW_NEW) begin : g_new_chk
        AST_FULL_WRITE_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
            (clk_en && rd_en && wr_en && (&byte_en)) |=> (rdata == $past(wdata))); // R3
    end
endmodule

// File: tb/spram_rdctl_tb_top.sv
module spram_rdctl_tb_top;
    localparam int DEPTH  = 64;
    localparam int DATA_W = 18;
    localparam int BYTE_W = 9;
    localparam int AW     = $clog2(DEPTH);
    localparam int LANES  = DATA_W / BYTE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clk_en = 1'b0;
    logic [AW-1:0]     addr = '0;
    logic              addr_stall = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [LANES-1:0]  byte_en = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata_new;
    logic [DATA_W-1:0] rdata_old;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [DATA_W-1:0] mdl_mem [DEPTH];
    logic [AW-1:0]     mdl_addr;
    logic [DATA_W-1:0] exp_new;
    logic [DATA_W-1:0] exp_old;

    always #10 clk = ~clk;

    spram_rdctl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .BYTE_W(BYTE_W),
                  .RDW_MODE(spram_pkg::RDW_SHOW_NEW)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .addr(addr),
        .addr_stall(addr_stall), .wr_en(wr_en), .rd_en(rd_en),
        .byte_en(byte_en), .wdata(wdata), .rdata(rdata_new));

    spram_rdctl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .BYTE_W(BYTE_W),
                  .RDW_MODE(spram_pkg::RDW_SHOW_OLD)) dut_old_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .addr(addr),
        .addr_stall(addr_stall), .wr_en(wr_en), .rd_en(rd_en),
        .byte_en(byte_en), .wdata(wdata), .rdata(rdata_old));

    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] cur,
                                                input logic [DATA_W-1:0] nw,
                                                input logic [LANES-1:0] m);
        logic [DATA_W-1:0] r = cur;
        for (int k = 0; k < LANES; k++) begin
            if (m[k]) r[k*BYTE_W +: BYTE_W] = nw[k*BYTE_W +: BYTE_W];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: rdata=%h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic apply(input string tag, input bit ce, input bit st,
                         input logic [AW-1:0] a, input bit wr, input bit rd,
                         input logic [LANES-1:0] be, input logic [DATA_W-1:0] d);
        logic [AW-1:0]     ea;
        logic [DATA_W-1:0] prev;
        logic [DATA_W-1:0] nxt;
        clk_en = ce; addr_stall = st; addr = a; wr_en = wr; rd_en = rd;
        byte_en = be; wdata = d;
        @(posedge clk);
        if (ce) begin
            ea = st ? mdl_addr : a;
            mdl_addr = ea;
            prev = mdl_mem[ea];
            nxt  = merge(prev, d, be);
            if (wr) mdl_mem[ea] = nxt;
            if (rd) begin
                exp_new = wr ? nxt : prev;
                exp_old = prev;
            end
        end
        @(negedge clk);
        check({tag, " new-mode"}, rdata_new, exp_new);
        check({tag, " old-mode"}, rdata_old, exp_old);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        mdl_addr = '0;
        exp_new  = '0;
        exp_old  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset output", rdata_new, '0);
        check("R9 reset output", rdata_old, '0);

        // R9: held address is zero after reset; a stalled write lands at 0
        apply("R9 stalled write", 1, 1, 6'd5, 1, 0, 2'b11, 18'h2A5A5);
        apply("R9 read back 0", 1, 0, 6'd0, 0, 1, 2'b00, '0);

        // R1: fill every word with a full-width write, no read
        for (int i = 1; i < DEPTH; i++) begin
            apply("R1 fill", 1, 0, AW'(i), 1, 0, 2'b11, DATA_W'(i * 4099 + 17));
        end
        apply("R1 read", 1, 0, 6'd3, 0, 1, 2'b00, '0);

        // R5 and R2: masked write with rd_en low, then read back
        apply("R5 write no read", 1, 0, 6'd3, 1, 0, 2'b01, 18'h3FFFF);
        apply("R2 low lane only", 1, 0, 6'd3, 0, 1, 2'b00, '0);
        apply("R2 high lane only", 1, 0, 6'd7, 1, 0, 2'b10, 18'h15555);
        apply("R2 read high lane", 1, 0, 6'd7, 0, 1, 2'b00, '0);

        // R3 R4: read during write
        apply("R3 R4 rd during wr", 1, 0, 6'd4, 1, 1, 2'b10, 18'h0F0F0);
        apply("R3 R4 full rd wr", 1, 0, 6'd9, 1, 1, 2'b11, 18'h12345);
        apply("R1 read after", 1, 0, 6'd4, 0, 1, 2'b00, '0);

        // R8: clock enable low blocks the write and the read
        apply("R8 ce low", 0, 0, 6'd6, 1, 1, 2'b11, 18'h00001);
        apply("R8 verify", 1, 0, 6'd6, 0, 1, 2'b00, '0);

        // R6 R7: stall holds the address for writes and reads
        apply("R7 latch 10", 1, 0, 6'd10, 0, 1, 2'b00, '0);
        apply("R6 stalled write", 1, 1, 6'd20, 1, 0, 2'b11, 18'h0BEEF);
        apply("R6 stalled read", 1, 1, 6'd30, 0, 1, 2'b00, '0);
        apply("R7 addr 20 intact", 1, 0, 6'd20, 0, 1, 2'b00, '0);
        apply("R8 stall ce low", 0, 0, 6'd33, 0, 1, 2'b00, '0);
        apply("R6 R8 held addr", 1, 1, 6'd40, 0, 1, 2'b00, '0);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            apply("R1 R3 R4 R5 R6 random",
                  ($urandom % 100) < 85, ($urandom % 100) < 20,
                  AW'($urandom), $urandom % 2, $urandom % 2,
                  LANES'($urandom), DATA_W'($urandom));
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule